// File: doc/BRIEF.md
# Multi-core start release controller

This block lets boot software bring secondary processor cores of a clustered multiprocessor out of reset, one at a time. Each core has its own reset vector register, and that register drives the core's boot address output. A system-wide alive mask drives the per-core interrupt-enable outputs. A per-cluster startup register releases cores from reset. The alive mask and the startup register are independent. A core can be released without being marked alive; it then runs, but it gets no interrupts. A core can also be marked alive without being released.

A typical bring-up proceeds in three steps. Software writes the target core's vector. It then sets that core's bit in the alive mask. Finally it sets the core's bit in its cluster's startup register, and the core begins fetching from the programmed vector.

Two rules keep boot addresses fixed:
- The boot core's vector comes from a parameter and cannot be written.
- A core's vector is frozen once that core has been released.

The block also splits a packed 15-bit processor identifier into its core, cluster and die fields, and computes the global core number. A flat mode input covers systems that number all cores inside cluster 0.

Top module: `core_boot_ctrl`

## Requirements
- R1: After reset, every release output and every interrupt-enable output is 0. Core 0's vector equals the parameter BOOT_VEC, every other vector is 0, and reads of offsets 0x4 and 0x8 return 0.
- R2: A write to offset VEC_BASE + 16·n, where n is not 0, updates core n's vector output on the next cycle. A read of that offset returns the value written.
- R3: Writes to core 0's vector offset (VEC_BASE) are ignored. Its output and read-back stay at BOOT_VEC.
- R4: Once core n has been released, writes to its vector offset leave its vector unchanged.
- R5: Offset 0x4 holds the alive mask, with bit n for global core n. It is read/write, and core_irq_en equals the mask from the cycle after the write.
- R6: Offset 0x8 + 4·c is cluster c's startup register. Writing 1 to bit i releases global core c·CORES_PER_CLUSTER + i. Writing 0 clears nothing, and a release lasts until reset. A read returns the cluster's release bits.
- R7: A core that is released while its alive bit is clear is released, but its interrupt-enable output stays 0. Writing the alive mask never changes any release output.
- R8: With flat_mode = 0, id_core = cpu_id[7:0], id_cluster = cpu_id[10:8] and id_die = cpu_id[14:11]. id_global = cluster·CORES_PER_CLUSTER + core, and id_valid = 1 only when cluster < N_CLUSTERS and core < CORES_PER_CLUSTER.
- R9: With flat_mode = 1:
  - id_global equals the core field, and id_valid = 1 only when core < total cores.
  - The register at 0x8 covers all cores, with bit n for global core n, and its read returns the whole release mask.
  - Offset 0xC is unmapped: it reads 0 and writes to it are ignored.
- R10: A read of an unmapped offset returns 0, and a write to one changes no output. Examples are 0x0, a nonzero offset inside a vector window, and a startup register past the last cluster.
- R11: Read data is registered. It appears on bus_rdata the cycle after bus_rd and holds while bus_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flat_mode | input | 1 | All cores numbered inside cluster 0 |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| cpu_id | input | 15 | Packed processor identifier |
| id_core | output | 8 | Decoded core field |
| id_cluster | output | 3 | Decoded cluster field |
| id_die | output | 4 | Decoded die field |
| id_global | output | GIDX_W | Global core number |
| id_valid | output | 1 | Identifier names an existing core |
| core_vector | output | TOTAL×VEC_W | Per-core reset vector |
| core_release | output | TOTAL | Per-core reset release |
| core_irq_en | output | TOTAL | Per-core interrupt enable |

## Verification
The bench uses the default parameters: two clusters of four cores, 32-bit vectors and a nonzero BOOT_VEC. With these values, cluster 1's register sits at 0xC and the offset 0x10 falls past the last cluster. Flat mode can then release core 7, which sits outside the cluster-0 range in normal mode. One run covers the locked boot vector, a release into cluster 1 with interrupts enabled, and a release into cluster 0 without them. The same run then switches to flat mode and compares the whole release mask against the bench's own model.

// File: rtl/cbc_pkg.sv
package cbc_pkg;

  // Packed identifier: die[14:11], cluster[10:8], core[7:0]
  typedef struct packed {
    logic [3:0] die;
    logic [2:0] cluster;
    logic [7:0] core;
  } cpu_id_t;

  localparam int unsigned ALIVE_OFS = 32'h4;
  localparam int unsigned START_OFS = 32'h8;

  function automatic int unsigned global_index(input int unsigned cluster,
                                               input int unsigned core,
                                               input int unsigned cpc,
                                               input logic flat);
    if (flat) return core;
    return cluster * cpc + core;
  endfunction

  function automatic logic id_in_range(input int unsigned cluster,
                                       input int unsigned core,
                                       input int unsigned nclus,
                                       input int unsigned cpc,
                                       input logic flat);
    if (flat) return core < nclus * cpc;
    return (cluster < nclus) && (core < cpc);
  endfunction

endpackage

// File: rtl/cbc_id_decode.sv
module cbc_id_decode #(
  parameter int N_CLUSTERS        = 2,
  parameter int CORES_PER_CLUSTER = 4,
  parameter int GIDX_W            = 3
) (
  input  logic [14:0]       cpu_id,
  input  logic              flat_mode,
  output logic [7:0]        id_core,
  output logic [2:0]        id_cluster,
  output logic [3:0]        id_die,
  output logic [GIDX_W-1:0] id_global,
  output logic              id_valid
);
  import cbc_pkg::*;

  cpu_id_t     f;
  int unsigned g;

  always_comb begin
    f          = cpu_id_t'(cpu_id);
    id_core    = f.core;
    id_cluster = f.cluster;
    id_die     = f.die;
    g          = global_index(32'(f.cluster), 32'(f.core),
                              CORES_PER_CLUSTER, flat_mode);
    id_global  = GIDX_W'(g);
    id_valid   = id_in_range(32'(f.cluster), 32'(f.core), N_CLUSTERS,
                             CORES_PER_CLUSTER, flat_mode);
  end

endmodule

// File: rtl/cbc_addr_decode.sv
module cbc_addr_decode #(
  parameter int ADDR_W     = 12,
  parameter int N_CLUSTERS = 2,
  parameter int TOTAL      = 8,
  parameter int VEC_BASE   = 'h100,
  parameter int VEC_SHIFT  = 4,
  parameter int CL_W       = 1,
  parameter int GIDX_W     = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              flat_mode,
  output logic              hit_alive,
  output logic              hit_start,
  output logic [CL_W-1:0]   start_cluster,
  output logic              hit_vec,
  output logic [GIDX_W-1:0] vec_idx,
  output logic              unmapped
);
  import cbc_pkg::*;

  localparam int unsigned START_END = START_OFS + 4 * N_CLUSTERS;
  localparam int unsigned VEC_END   = VEC_BASE + (TOTAL << VEC_SHIFT);
  localparam int unsigned VEC_MASK  = (1 << VEC_SHIFT) - 1;

  int unsigned a;
  int unsigned cl;

  always_comb begin
    a             = 32'(addr);
    cl            = (a - START_OFS) >> 2;
    hit_alive     = (a == ALIVE_OFS);
    hit_start     = (a >= START_OFS) && (a < START_END) && (a[1:0] == 2'b00)
                    && (!flat_mode || cl == 0);
    start_cluster = hit_start ? CL_W'(cl) : '0;
    hit_vec       = (a >= VEC_BASE) && (a < VEC_END) && ((a & VEC_MASK) == 0);
    vec_idx       = hit_vec ? GIDX_W'((a - VEC_BASE) >> VEC_SHIFT) : '0;
    unmapped      = !(hit_alive || hit_start || hit_vec);
  end

endmodule

// File: rtl/cbc_vector_bank.sv
module cbc_vector_bank #(
  parameter int TOTAL    = 8,
  parameter int VEC_W    = 32,
  parameter int DATA_W   = 32,
  parameter int GIDX_W   = 3,
  parameter logic [VEC_W-1:0] BOOT_VEC = '0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr,
  input  logic                         hit_vec,
  input  logic [GIDX_W-1:0]            vec_idx,
  input  logic [DATA_W-1:0]            wdata,
  input  logic [TOTAL-1:0]             released,
  output logic [TOTAL-1:0][VEC_W-1:0]  vectors,
  output logic [DATA_W-1:0]            rd_val
);

  for (genvar i = 0; i < TOTAL; i++) begin : g_core
    if (i == 0) begin : g_boot
      // Boot core vector is fixed at BOOT_VEC
      assign vectors[i] = BOOT_VEC;
    end else begin : g_sec
      logic             we;
      logic [VEC_W-1:0] vec_q;
      assign we = wr && hit_vec && (vec_idx == GIDX_W'(i)) && !released[i];
      always_ff @(posedge clk) begin
        if (!rst_n)  vec_q <= '0;
        else if (we) vec_q <= wdata[VEC_W-1:0];
      end
      assign vectors[i] = vec_q;
    end
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < TOTAL; i++)
      if (vec_idx == GIDX_W'(i)) rd_val = DATA_W'(vectors[i]);
  end

endmodule

// File: rtl/cbc_release_ctrl.sv
module cbc_release_ctrl #(
  parameter int N_CLUSTERS        = 2,
  parameter int CORES_PER_CLUSTER = 4,
  parameter int TOTAL             = 8,
  parameter int DATA_W            = 32,
  parameter int CL_W              = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flat_mode,
  input  logic              alive_wr,
  input  logic              start_wr,
  input  logic [CL_W-1:0]   start_cluster,
  input  logic [DATA_W-1:0] wdata,
  output logic [TOTAL-1:0]  alive,
  output logic [TOTAL-1:0]  released,
  output logic [DATA_W-1:0] alive_rd,
  output logic [DATA_W-1:0] start_rd
);
  localparam int CPC = CORES_PER_CLUSTER;

  logic [TOTAL-1:0] set_mask;

  always_comb begin
    set_mask = '0;
    if (flat_mode) begin
      set_mask = wdata[TOTAL-1:0];
    end else begin
      for (int c = 0; c < N_CLUSTERS; c++)
        if (start_cluster == CL_W'(c)) set_mask[c*CPC +: CPC] = wdata[CPC-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alive    <= '0;
      released <= '0;
    end else begin
      if (alive_wr) alive    <= wdata[TOTAL-1:0];
      if (start_wr) released <= released | set_mask;
    end
  end

  assign alive_rd = DATA_W'(alive);

  always_comb begin
    start_rd = '0;
    if (flat_mode) begin
      start_rd = DATA_W'(released);
    end else begin
      for (int c = 0; c < N_CLUSTERS; c++)
        if (start_cluster == CL_W'(c)) start_rd = DATA_W'(released[c*CPC +: CPC]);
    end
  end

endmodule

// File: rtl/core_boot_ctrl.sv
module core_boot_ctrl #(
  parameter int N_CLUSTERS        = 2,
  parameter int CORES_PER_CLUSTER = 4,
  parameter int ADDR_W            = 12,
  parameter int DATA_W            = 32,
  parameter int VEC_W             = 32,
  parameter int VEC_BASE          = 'h100,
  parameter int VEC_SHIFT         = 4,
  parameter logic [VEC_W-1:0] BOOT_VEC = 32'h0000_8000,
  localparam int TOTAL  = N_CLUSTERS * CORES_PER_CLUSTER,
  localparam int GIDX_W = (TOTAL > 1) ? $clog2(TOTAL) : 1,
  localparam int CL_W   = (N_CLUSTERS > 1) ? $clog2(N_CLUSTERS) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flat_mode,
  input  logic                         bus_wr,
  input  logic                         bus_rd,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic [DATA_W-1:0]            bus_wdata,
  output logic [DATA_W-1:0]            bus_rdata,
  input  logic [14:0]                  cpu_id,
  output logic [7:0]                   id_core,
  output logic [2:0]                   id_cluster,
  output logic [3:0]                   id_die,
  output logic [GIDX_W-1:0]            id_global,
  output logic                         id_valid,
  output logic [TOTAL-1:0][VEC_W-1:0]  core_vector,
  output logic [TOTAL-1:0]             core_release,
  output logic [TOTAL-1:0]             core_irq_en
);

  logic              hit_alive, hit_start, hit_vec, acc_unmapped;
  logic [CL_W-1:0]   start_cluster;
  logic [GIDX_W-1:0] vec_idx;
  logic              alive_wr_ev, start_wr_ev;
  logic [TOTAL-1:0]  alive_q, released_q;
  logic [DATA_W-1:0] alive_rd, start_rd, vec_rd;

  cbc_addr_decode #(
    .ADDR_W(ADDR_W), .N_CLUSTERS(N_CLUSTERS), .TOTAL(TOTAL),
    .VEC_BASE(VEC_BASE), .VEC_SHIFT(VEC_SHIFT), .CL_W(CL_W), .GIDX_W(GIDX_W)
  ) u_dec (
    .addr(bus_addr), .flat_mode(flat_mode), .hit_alive(hit_alive),
    .hit_start(hit_start), .start_cluster(start_cluster), .hit_vec(hit_vec),
    .vec_idx(vec_idx), .unmapped(acc_unmapped)
  );

  assign alive_wr_ev = bus_wr && hit_alive;
  assign start_wr_ev = bus_wr && hit_start;

  cbc_release_ctrl #(
    .N_CLUSTERS(N_CLUSTERS), .CORES_PER_CLUSTER(CORES_PER_CLUSTER),
    .TOTAL(TOTAL), .DATA_W(DATA_W), .CL_W(CL_W)
  ) u_rel (
    .clk(clk), .rst_n(rst_n), .flat_mode(flat_mode), .alive_wr(alive_wr_ev),
    .start_wr(start_wr_ev), .start_cluster(start_cluster), .wdata(bus_wdata),
    .alive(alive_q), .released(released_q), .alive_rd(alive_rd),
    .start_rd(start_rd)
  );

  cbc_vector_bank #(
    .TOTAL(TOTAL), .VEC_W(VEC_W), .DATA_W(DATA_W), .GIDX_W(GIDX_W),
    .BOOT_VEC(BOOT_VEC)
  ) u_vec (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .hit_vec(hit_vec),
    .vec_idx(vec_idx), .wdata(bus_wdata), .released(released_q),
    .vectors(core_vector), .rd_val(vec_rd)
  );

  cbc_id_decode #(
    .N_CLUSTERS(N_CLUSTERS), .CORES_PER_CLUSTER(CORES_PER_CLUSTER),
    .GIDX_W(GIDX_W)
  ) u_id (
    .cpu_id(cpu_id), .flat_mode(flat_mode), .id_core(id_core),
    .id_cluster(id_cluster), .id_die(id_die), .id_global(id_global),
    .id_valid(id_valid)
  );

  assign core_release = released_q;
  assign core_irq_en  = alive_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if (acc_unmapped)   bus_rdata <= '0;
      else if (hit_alive) bus_rdata <= alive_rd;
      else if (hit_start) bus_rdata <= start_rd;
      else                bus_rdata <= vec_rd;
    end
  end

endmodule

// File: rtl/cbc_checker.sv
module cbc_checker #(
  parameter int TOTAL  = 8,
  parameter int VEC_W  = 32,
  parameter int DATA_W = 32
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        bus_rd,
  input logic [DATA_W-1:0]           bus_wdata,
  input logic [DATA_W-1:0]           bus_rdata,
  input logic [TOTAL-1:0][VEC_W-1:0] core_vector,
  input logic [TOTAL-1:0]            core_release,
  input logic [TOTAL-1:0]            core_irq_en,
  input logic                        acc_unmapped,
  input logic                        alive_wr_ev
);

  assert_release_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((core_release & $past(core_release)) == $past(core_release)));

  assert_boot_vec_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(core_vector[0]));

  assert_irq_follows_alive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    alive_wr_ev |=> (core_irq_en == $past(bus_wdata[TOTAL-1:0])));

  assert_alive_no_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    alive_wr_ev |=> $stable(core_release));

  assert_unmapped_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && acc_unmapped) |=> (bus_rdata == '0));

  assert_rdata_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

  for (genvar i = 1; i < TOTAL; i++) begin : g_frz
    assert_frozen_vector_R4: assert property (@(posedge clk) disable iff (!rst_n)
      core_release[i] |=> $stable(core_vector[i]));
  end

endmodule

bind core_boot_ctrl cbc_checker #(
  .TOTAL(TOTAL), .VEC_W(VEC_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .core_vector(core_vector),
  .core_release(core_release), .core_irq_en(core_irq_en),
  .acc_unmapped(acc_unmapped), .alive_wr_ev(alive_wr_ev)
);

// File: tb/tb_core_boot_ctrl.sv
module tb_core_boot_ctrl;
  localparam int NCL = 2;
  localparam int CPC = 4;
  localparam int TOT = NCL * CPC;
  localparam logic [31:0] BOOTV = 32'h0000_8000;

  logic clk = 0, rst_n = 0, flat_mode = 0, bus_wr = 0, bus_rd = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [14:0] cpu_id = '0;
  logic [7:0] id_core;
  logic [2:0] id_cluster;
  logic [3:0] id_die;
  logic [2:0] id_global;
  logic id_valid;
  logic [TOT-1:0][31:0] core_vector;
  logic [TOT-1:0] core_release, core_irq_en;

  int vectors = 0, miscompares = 0;
  logic [TOT-1:0] exp_rel = '0;

  always #10 clk = ~clk;

  core_boot_ctrl #(.N_CLUSTERS(NCL), .CORES_PER_CLUSTER(CPC), .BOOT_VEC(BOOTV)) dut (
    .clk(clk), .rst_n(rst_n), .flat_mode(flat_mode), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cpu_id(cpu_id), .id_core(id_core),
    .id_cluster(id_cluster), .id_die(id_die), .id_global(id_global),
    .id_valid(id_valid), .core_vector(core_vector),
    .core_release(core_release), .core_irq_en(core_irq_en)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 release", 64'(core_release), 0);
    check("R1 irq_en", 64'(core_irq_en), 0);
    check("R1 vec0", 64'(core_vector[0]), 64'(BOOTV));
    check("R1 vec3", 64'(core_vector[3]), 0);
    rd(12'h004, d); check("R1 alive read", 64'(d), 0);
    rd(12'h008, d); check("R1 start read", 64'(d), 0);
  endtask

  task automatic t_vec_write();
    logic [31:0] d;
    wr(12'h150, 32'h1234_5670);
    check("R2 vec5 out", 64'(core_vector[5]), 64'h1234_5670);
    rd(12'h150, d); check("R2 vec5 read", 64'(d), 64'h1234_5670);
    @(negedge clk); @(negedge clk);
    check("R11 rdata held", 64'(bus_rdata), 64'h1234_5670);
  endtask

  task automatic t_boot_lock();
    logic [31:0] d;
    wr(12'h100, 32'hDEAD_0000);
    check("R3 vec0 out", 64'(core_vector[0]), 64'(BOOTV));
    rd(12'h100, d); check("R3 vec0 read", 64'(d), 64'(BOOTV));
  endtask

  task automatic t_alive();
    logic [31:0] d;
    wr(12'h004, 32'h0000_0021);
    check("R5 irq_en", 64'(core_irq_en), 64'h21);
    check("R7 alive no release", 64'(core_release), 0);
    rd(12'h004, d); check("R5 alive read", 64'(d), 64'h21);
  endtask

  task automatic t_start_cluster1();
    logic [31:0] d;
    wr(12'h00C, 32'h2); exp_rel[5] = 1'b1;
    check("R6 release c1", 64'(core_release), 64'(exp_rel));
    check("R6 irq of released alive", 64'(core_irq_en[5]), 1);
    rd(12'h00C, d); check("R6 c1 read", 64'(d), 64'h2);
    wr(12'h00C, 32'h0);
    check("R6 sticky", 64'(core_release), 64'(exp_rel));
  endtask

  task automatic t_start_no_alive();
    logic [31:0] d;
    wr(12'h008, 32'h4); exp_rel[2] = 1'b1;
    check("R7 released", 64'(core_release), 64'(exp_rel));
    check("R7 irq off", 64'(core_irq_en[2]), 0);
    rd(12'h008, d); check("R6 c0 read", 64'(d), 64'h4);
  endtask

  task automatic t_frozen();
    wr(12'h150, 32'hAAAA_5550);
    check("R4 frozen vec5", 64'(core_vector[5]), 64'h1234_5670);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    rd(12'h000, d); check("R10 read 0x0", 64'(d), 0);
    wr(12'h118, 32'h5555_0000);
    check("R10 window ofs vec1", 64'(core_vector[1]), 0);
    rd(12'h118, d); check("R10 read 0x118", 64'(d), 0);
    wr(12'h010, 32'hF);
    check("R10 past last cluster", 64'(core_release), 64'(exp_rel));
    rd(12'h010, d); check("R10 read 0x10", 64'(d), 0);
  endtask

  task automatic t_id_normal();
    cpu_id = {4'd3, 3'd1, 8'd2};
    #1;
    check("R8 core", 64'(id_core), 2);
    check("R8 cluster", 64'(id_cluster), 1);
    check("R8 die", 64'(id_die), 3);
    check("R8 global", 64'(id_global), 6);
    check("R8 valid", 64'(id_valid), 1);
    cpu_id = {4'd0, 3'd0, 8'd5};
    #1;
    check("R8 core out of range", 64'(id_valid), 0);
  endtask

  task automatic t_flat();
    logic [31:0] d;
    @(negedge clk); flat_mode = 1;
    cpu_id = {4'd0, 3'd1, 8'd5};
    #1;
    check("R9 global", 64'(id_global), 5);
    check("R9 valid", 64'(id_valid), 1);
    wr(12'h008, 32'h80); exp_rel[7] = 1'b1;
    check("R9 release core7", 64'(core_release), 64'(exp_rel));
    rd(12'h008, d); check("R9 full mask read", 64'(d), 64'(exp_rel));
    wr(12'h00C, 32'h1);
    check("R9 c1 ignored", 64'(core_release), 64'(exp_rel));
    rd(12'h00C, d); check("R9 c1 reads zero", 64'(d), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_vec_write();
    t_boot_lock();
    t_alive();
    t_start_cluster1();
    t_start_no_alive();
    t_frozen();
    t_unmapped();
    t_id_normal();
    t_flat();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule